// File: doc/BRIEF.md
# Single-Wire Bus Device Slot Decoder

This block is the device-side front end of a single-wire open-drain bus. It watches the bus level, which has already been synchronized to the clock. A long low from the master is recognised as a bus reset. The device answers that reset with a timed presence pulse. Each shorter low that starts at a falling edge is timed as a bit slot.

In a write slot the block samples the line at a fixed offset and hands the bit upward with a one-cycle strobe. In a read slot it takes a transmit bit from the layer above. A zero is sent by pulling the line low for a fixed window, and a one is sent by leaving the line released. When the read slot ends, the block asks for the next transmit bit. The upper layer sets a mode input that chooses whether the next slot is a write or a read.

All timing is counted in microsecond ticks supplied from outside. The output `pull_low` drives the open-drain pull-down of the pin.

Top module: `owb_slot_slave`

## Requirements
- R1: A low that lasts RESET_MIN_US (480) ticks produces a one-cycle `bus_reset` strobe in the cycle after the tick that completes that count. A low that is even one tick shorter produces no strobe. A reset also ends any slot in progress.
- R2: After the rising edge that ends a reset, `pull_low` stays 0 for PRES_WAIT_US (30) ticks. It is then 1 for exactly PRES_LOW_US (120) ticks and then returns to 0. With one tick per clock, it is 1 from the 31st through the 150th cycle after the release.
- R3: In a write slot the line is sampled on the SAMPLE_US-th (30th) tick after the falling edge. `rx_valid` pulses for one cycle right after that tick. At the same time `rx_bit` shows the sampled level: high gives 1 and low gives 0.
- R4: In a read slot with `tx_bit` = 0, `pull_low` is 1 from the cycle after the falling edge until the HOLD0_US-th (30th) tick.
- R5: In a read slot with `tx_bit` = 1, `pull_low` stays 0 for the whole slot.
- R6: A read slot ends on its HOLD0_US-th tick. At that point `tx_req` pulses for one cycle and `pull_low` returns to 0 in the same cycle.
- R7: `mode_read` and `tx_bit` are taken at the falling edge that starts a slot: `mode_read` = 1 makes a read slot and 0 makes a write slot. A write slot never drives the line, and slots separated by a short recovery time decode one after another.
- R8: While a reset answer is pending (armed, waiting or pulsing), falling edges do not start a slot, so no `rx_valid` or `tx_req` appears. The presence timing is not disturbed.
- R9: While `rst_n` is low and after it is released, all outputs are 0 until bus activity occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| line_in | input | 1 | Synchronized bus level |
| mode_read | input | 1 | Slot kind for the next slot: 1 read, 0 write |
| tx_bit | input | 1 | Bit to send in the next read slot |
| pull_low | output | 1 | Open-drain pull-down enable for the bus |
| bus_reset | output | 1 | One-cycle strobe on a detected bus reset |
| rx_valid | output | 1 | One-cycle strobe for a received write bit |
| rx_bit | output | 1 | Received bit value, valid with rx_valid |
| tx_req | output | 1 | One-cycle request for the next transmit bit |

## Verification
There are two counters, the low-length counter and the slot tick counter. An off-by-one in either moves the `bus_reset`, `rx_valid` or `tx_req` strobe by exactly one cycle, and the bench catches this because it samples the cycles on both sides of each strobe. If the slot state machine starts a slot that should have been blocked, a stray `rx_valid` appears about 30 cycles later, inside the presence window. A wrong latched transmit bit shows within one cycle of the falling edge as a wrong `pull_low` level. A stuck presence state shows as `pull_low` missing at cycle 31, or still set at cycle 151, after the reset release.

// File: rtl/owb_pkg.sv
package owb_pkg;

  typedef enum logic [1:0] {
    PR_IDLE  = 2'd0,
    PR_ARMED = 2'd1,
    PR_WAIT  = 2'd2,
    PR_LOW   = 2'd3
  } pres_state_e;

  typedef enum logic {
    SL_IDLE = 1'b0,
    SL_BUSY = 1'b1
  } slot_state_e;

  // Width able to hold values 0..limit
  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // True on the tick that completes a span of 'span' ticks counted from 0
  function automatic logic last_tick(input int unsigned cnt,
                                     input int unsigned span,
                                     input logic tick);
    return tick && (cnt == span - 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owb_line_watch.sv
module owb_line_watch #(
  parameter int unsigned RESET_MIN_US = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  output logic fall,
  output logic rise,
  output logic reset_hit
);
  import owb_pkg::*;

  localparam int unsigned LW = cnt_bits(RESET_MIN_US);

  logic          line_q;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      line_q <= line_in;
      if (line_in) begin
        low_cnt <= '0;
      end else if (tick && (low_cnt < LW'(RESET_MIN_US))) begin
        low_cnt <= low_cnt + LW'(1);
      end
    end
  end

  always_comb begin
    fall      = line_q && !line_in;
    rise      = !line_q && line_in;
    reset_hit = !line_in && last_tick(32'(low_cnt), RESET_MIN_US, tick);
  end

endmodule

// File: rtl/owb_presence.sv
module owb_presence #(
  parameter int unsigned WAIT_US = 30,
  parameter int unsigned LOW_US  = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rise,
  input  logic reset_hit,
  output logic pres_low,
  output logic pres_busy
);
  import owb_pkg::*;

  localparam int unsigned PW = cnt_bits(max2(WAIT_US, LOW_US));

  pres_state_e   state;
  logic [PW-1:0] cnt;
  logic          wait_done;
  logic          low_done;

  always_comb begin
    wait_done = last_tick(32'(cnt), WAIT_US, tick);
    low_done  = last_tick(32'(cnt), LOW_US, tick);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PR_IDLE;
      cnt   <= '0;
    end else if (reset_hit) begin
      state <= PR_ARMED;
      cnt   <= '0;
    end else begin
      unique case (state)
        PR_IDLE: cnt <= '0;
        PR_ARMED: begin
          cnt <= '0;
          if (rise) state <= PR_WAIT;
        end
        PR_WAIT: begin
          if (wait_done) begin
            state <= PR_LOW;
            cnt   <= '0;
          end else if (tick) begin
            cnt <= cnt + PW'(1);
          end
        end
        PR_LOW: begin
          if (low_done) begin
            state <= PR_IDLE;
            cnt   <= '0;
          end else if (tick) begin
            cnt <= cnt + PW'(1);
          end
        end
        default: state <= PR_IDLE;
      endcase
    end
  end

  always_comb begin
    pres_low  = (state == PR_LOW);
    pres_busy = (state != PR_IDLE);
  end

endmodule

// File: rtl/owb_slot.sv
module owb_slot #(
  parameter int unsigned SAMPLE_US = 30,
  parameter int unsigned HOLD0_US  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_in,
  input  logic fall,
  input  logic block,
  input  logic abort,
  input  logic mode_read,
  input  logic tx_bit,
  output logic rx_valid,
  output logic rx_bit,
  output logic tx_req,
  output logic drive_low,
  output logic busy,
  output logic is_read
);
  import owb_pkg::*;

  localparam int unsigned SW = cnt_bits(max2(SAMPLE_US, HOLD0_US));

  slot_state_e   state;
  logic [SW-1:0] cnt;
  logic          kind_read;
  logic          send_zero;
  logic          start;
  logic          span_done;
  int unsigned   span;

  always_comb begin
    start     = fall && !block && (state == SL_IDLE);
    span      = kind_read ? HOLD0_US : SAMPLE_US;
    span_done = (state == SL_BUSY) && last_tick(32'(cnt), span, tick);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SL_IDLE;
      cnt       <= '0;
      kind_read <= 1'b0;
      send_zero <= 1'b0;
      rx_valid  <= 1'b0;
      rx_bit    <= 1'b0;
      tx_req    <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      if (abort) begin
        state     <= SL_IDLE;
        cnt       <= '0;
        send_zero <= 1'b0;
      end else if (start) begin
        state     <= SL_BUSY;
        cnt       <= '0;
        kind_read <= mode_read;
        send_zero <= mode_read && !tx_bit;
      end else if (state == SL_BUSY) begin
        if (span_done) begin
          state     <= SL_IDLE;
          cnt       <= '0;
          send_zero <= 1'b0;
          if (kind_read) begin
            tx_req <= 1'b1;
          end else begin
            rx_valid <= 1'b1;
            rx_bit   <= line_in;
          end
        end else if (tick) begin
          cnt <= cnt + SW'(1);
        end
      end
    end
  end

  always_comb begin
    busy      = (state == SL_BUSY);
    is_read   = kind_read;
    drive_low = busy && kind_read && send_zero;
  end

endmodule

// File: rtl/owb_slot_slave.sv
module owb_slot_slave #(
  parameter int unsigned RESET_MIN_US = 480,
  parameter int unsigned PRES_WAIT_US = 30,
  parameter int unsigned PRES_LOW_US  = 120,
  parameter int unsigned SAMPLE_US    = 30,
  parameter int unsigned HOLD0_US     = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic line_in,
  input  logic mode_read,
  input  logic tx_bit,
  output logic pull_low,
  output logic bus_reset,
  output logic rx_valid,
  output logic rx_bit,
  output logic tx_req
);

  // Named internal events, also observed by the bound checker
  logic fall_w;
  logic rise_w;
  logic reset_hit_w;
  logic pres_low_w;
  logic pres_busy_w;
  logic slot_drive_w;
  logic slot_busy_w;
  logic slot_read_w;

  owb_line_watch #(
    .RESET_MIN_US(RESET_MIN_US)
  ) watch_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (us_tick),
    .line_in  (line_in),
    .fall     (fall_w),
    .rise     (rise_w),
    .reset_hit(reset_hit_w)
  );

  owb_presence #(
    .WAIT_US(PRES_WAIT_US),
    .LOW_US (PRES_LOW_US)
  ) pres_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (us_tick),
    .rise     (rise_w),
    .reset_hit(reset_hit_w),
    .pres_low (pres_low_w),
    .pres_busy(pres_busy_w)
  );

  owb_slot #(
    .SAMPLE_US(SAMPLE_US),
    .HOLD0_US (HOLD0_US)
  ) slot_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (us_tick),
    .line_in  (line_in),
    .fall     (fall_w),
    .block    (pres_busy_w),
    .abort    (reset_hit_w),
    .mode_read(mode_read),
    .tx_bit   (tx_bit),
    .rx_valid (rx_valid),
    .rx_bit   (rx_bit),
    .tx_req   (tx_req),
    .drive_low(slot_drive_w),
    .busy     (slot_busy_w),
    .is_read  (slot_read_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bus_reset <= 1'b0;
    else        bus_reset <= reset_hit_w;
  end

  always_comb pull_low = pres_low_w || slot_drive_w;

endmodule

// File: rtl/owb_slot_slave_chk.sv
module owb_slot_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic reset_hit,
  input logic pres_busy,
  input logic pres_low,
  input logic slot_busy,
  input logic slot_read,
  input logic slot_drive,
  input logic pull_low,
  input logic bus_reset,
  input logic rx_valid,
  input logic tx_req
);

  assert_reset_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);

  assert_reset_aborts_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_hit |=> !slot_busy);

  assert_rx_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(slot_busy && !slot_read));

  assert_single_driver_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pres_low, slot_drive}));

  assert_txreq_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> ($past(slot_busy && slot_read) && !slot_drive));

  assert_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_busy && !slot_read) |-> !pull_low);

  assert_presence_blocks_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pres_busy |-> !slot_busy);

endmodule

bind owb_slot_slave owb_slot_slave_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reset_hit (reset_hit_w),
  .pres_busy (pres_busy_w),
  .pres_low  (pres_low_w),
  .slot_busy (slot_busy_w),
  .slot_read (slot_read_w),
  .slot_drive(slot_drive_w),
  .pull_low  (pull_low),
  .bus_reset (bus_reset),
  .rx_valid  (rx_valid),
  .tx_req    (tx_req)
);

// File: tb/owb_slot_slave_tb.sv
module owb_slot_slave_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b1;
  logic m_low = 1'b0;
  logic mode_read = 1'b0;
  logic tx_bit = 1'b1;
  logic line;
  logic pull_low, bus_reset, rx_valid, rx_bit, tx_req;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Open-drain wired level: low if either side pulls
  assign line = !(m_low || pull_low);

  owb_slot_slave dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .line_in  (line),
    .mode_read(mode_read),
    .tx_bit   (tx_bit),
    .pull_low (pull_low),
    .bus_reset(bus_reset),
    .rx_valid (rx_valid),
    .rx_bit   (rx_bit),
    .tx_req   (tx_req)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    check("R9", "pull_low", int'(pull_low), 0);
    check("R9", "bus_reset", int'(bus_reset), 0);
    check("R9", "rx_valid", int'(rx_valid), 0);
    check("R9", "tx_req", int'(tx_req), 0);
  endtask

  // R1, R2: full reset and presence answer
  task automatic t_reset_presence;
    int strobes = 0;
    mode_read = 1'b0;
    m_low = 1'b1;
    for (int k = 1; k <= 500; k++) begin
      @(negedge clk);
      if (bus_reset) strobes++;
      if (k == 479) check("R1", "bus_reset before threshold", int'(bus_reset), 0);
      if (k == 480) check("R1", "bus_reset at threshold", int'(bus_reset), 1);
      if (k == 481) check("R1", "bus_reset one cycle", int'(bus_reset), 0);
    end
    check("R1", "reset strobe count", strobes, 1);
    m_low = 1'b0;
    for (int j = 1; j <= 155; j++) begin
      @(negedge clk);
      if (j == 30)  check("R2", "pull_low during wait", int'(pull_low), 0);
      if (j == 31)  check("R2", "pull_low at presence start", int'(pull_low), 1);
      if (j == 150) check("R2", "pull_low at presence end", int'(pull_low), 1);
      if (j == 151) check("R2", "pull_low after presence", int'(pull_low), 0);
    end
    idle(10);
  endtask

  // R1: one tick short of a reset
  task automatic t_short_low;
    int strobes = 0;
    int pulls = 0;
    mode_read = 1'b0;
    m_low = 1'b1;
    for (int k = 1; k <= 479; k++) begin
      @(negedge clk);
      if (bus_reset) strobes++;
    end
    m_low = 1'b0;
    for (int j = 1; j <= 170; j++) begin
      @(negedge clk);
      if (bus_reset) strobes++;
      if (pull_low) pulls++;
    end
    check("R1", "no reset for 479 tick low", strobes, 0);
    check("R1", "no presence after short low", pulls, 0);
  endtask

  // R3, R7: one write slot
  task automatic t_write(input logic b);
    int hold = b ? 5 : 60;
    int pulls = 0;
    mode_read = 1'b0;
    tx_bit = 1'b0;
    m_low = 1'b1;
    for (int k = 1; k <= 62; k++) begin
      @(negedge clk);
      if (pull_low) pulls++;
      if (k == 30) check("R3", "rx_valid before sample", int'(rx_valid), 0);
      if (k == 31) begin
        check("R3", "rx_valid at sample", int'(rx_valid), 1);
        check("R3", "rx_bit value", int'(rx_bit), int'(b));
      end
      if (k == 32) check("R3", "rx_valid one cycle", int'(rx_valid), 0);
      if (k == hold) m_low = 1'b0;
    end
    check("R7", "write slot never drives", pulls, 0);
    idle(5);
  endtask

  // R4, R5, R6: one read slot
  task automatic t_read(input logic b);
    mode_read = 1'b1;
    tx_bit = b;
    m_low = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 2) begin
        m_low = 1'b0;
        tx_bit = ~b;
      end
      if (k == 1)  check(b ? "R5" : "R4", "pull_low at slot start", int'(pull_low), b ? 0 : 1);
      if (k == 10) check(b ? "R5" : "R4", "line mid slot", int'(line), b ? 1 : 0);
      if (k == 30) check(b ? "R5" : "R4", "pull_low last held cycle", int'(pull_low), b ? 0 : 1);
      if (k == 30) check("R6", "tx_req before end", int'(tx_req), 0);
      if (k == 31) begin
        check("R6", "tx_req at end", int'(tx_req), 1);
        check("R6", "pull_low released", int'(pull_low), 0);
      end
      if (k == 32) check("R6", "tx_req one cycle", int'(tx_req), 0);
    end
    mode_read = 1'b0;
    idle(5);
  endtask

  // R7: back-to-back write slots with short recovery
  task automatic t_burst;
    logic [3:0] pat = 4'b1011;
    for (int i = 0; i < 4; i++) begin
      logic b = pat[i];
      int got = 0;
      int val = 0;
      mode_read = 1'b0;
      m_low = 1'b1;
      for (int k = 1; k <= 34; k++) begin
        @(negedge clk);
        if (rx_valid) begin
          got++;
          val = int'(rx_bit);
        end
        if (k == (b ? 3 : 33)) m_low = 1'b0;
      end
      check("R7", "burst strobe count", got, 1);
      check("R7", "burst bit value", val, int'(b));
      idle(2);
    end
  endtask

  // R8: falling edges during the presence answer are ignored
  task automatic t_ignore_during_presence;
    int strobes = 0;
    mode_read = 1'b0;
    m_low = 1'b1;
    idle(485);
    m_low = 1'b0;
    for (int j = 1; j <= 170; j++) begin
      @(negedge clk);
      if (j == 5)  m_low = 1'b1;
      if (j == 8)  m_low = 1'b0;
      if (j == 31) check("R8", "presence kept its timing", int'(pull_low), 1);
      if (rx_valid || tx_req) strobes++;
    end
    check("R8", "no slot strobes during presence", strobes, 0);
    idle(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    t_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    t_reset_state();
    t_reset_presence();
    t_write(1'b1);
    t_write(1'b0);
    t_read(1'b0);
    t_read(1'b1);
    t_burst();
    t_short_low();
    t_ignore_during_presence();
    t_write(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule